// File: doc/BRIEF.md
# Cache Maintenance Instruction Decoder

This block takes one 32-bit cache-maintenance instruction word per cycle, together with the core's configuration and the cache attribute of the address that the word targets. It checks whether the word belongs to this instruction class and pulls out the operation number, the base register number and a 9-bit signed displacement, which it widens to the full offset width. It then sorts the operation into an index, implementation-specific or hit class and names the cache level that the operation addresses.

A fixed chain of legality checks follows. A core with no memory system and no cache of any kind rejects the word as a reserved instruction. A user-translated variant on a core without that feature is rejected the same way. A disabled system coprocessor gives a coprocessor-unusable cause. Any word that passes these checks becomes one of three things: a request to the cache-operation unit, a silent completion for unused operation numbers, or a silent completion for uncached targets on newer architecture revisions. Every result appears on registered outputs one clock after the input strobe.

Top module: `cmd_decoder`

## Requirements
- R1: A word is accepted only if bits 31:26 are 101001, bits 14:11 are 0111, bit 10 is 0 and bits 9:8 are 01 or 10. Any other word leaves every output low in the following cycle.
- R2: For an accepted word, the operation number is taken from bits 25:21 and the base register from bits 20:16. The offset is the 9-bit value {bit 15, bits 7:0}, sign-extended to OFF_W bits. The user-translation flag is 1 exactly when bits 9:8 are 10.
- R3: The outcome of a strobed word appears exactly one cycle after the strobe. In any other cycle all of req_valid, exc_valid and nop_done are low. At most one of the three is high at a time.
- R4: When the no-memory-system flag is set and all five cache presence inputs are 0, exc_valid rises with exc_cause 1 (reserved instruction). The cause field carries only 0 (none), 1 (reserved instruction) or 2 (coprocessor unusable), and it is 0 whenever exc_valid is low. A misaligned offset never raises any other cause.
- R5: If R4 does not apply, a user-translation word on a core without that feature gives exc_cause 1.
- R6: If R4 and R5 do not apply, a disabled system coprocessor gives exc_cause 2.
- R7: req_class is 0 for operations 0 to 11 (index), 1 for operations 12 to 15 (implementation-specific) and 2 for operations 16 and above (hit). req_level is bits 1:0 of the operation number, with 0 meaning instruction, 1 data, 2 tertiary and 3 secondary.
- R8: A legal word whose attribute is 2 or 7 (uncached) on a revision of 2 or more raises nop_done and issues no request.
- R9: A legal word with operation number 24, 30 or 31 raises nop_done and issues no request. This check ranks above R8.
- R10: req_unpred is 1 when an index-class operation targets a mapped address, or when an uncached attribute meets a revision below 2. The request is still issued in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word strobe |
| instr | input | 32 | Instruction word |
| no_memsys | input | 1 | Core flagged as having no memory system |
| has_l1i | input | 1 | Level-1 instruction cache present |
| has_l1d | input | 1 | Level-1 data cache present |
| has_sec | input | 1 | Secondary cache present |
| has_ter | input | 1 | Tertiary cache present |
| has_l2ctl | input | 1 | Level-2 controller configured |
| uxlate_ok | input | 1 | User-translation variant implemented |
| arch_rev | input | REV_W | Architecture revision |
| cp0_en | input | 1 | System coprocessor enabled |
| cca | input | CCA_W | Cache attribute of the translated address |
| addr_mapped | input | 1 | Target address is mapped |
| req_valid | output | 1 | Request to the cache-operation unit |
| req_op | output | 5 | Operation number |
| req_base | output | 5 | Base register number |
| req_level | output | 2 | Target cache level |
| req_class | output | 2 | Index, implementation-specific or hit |
| req_offset | output | OFF_W | Sign-extended offset |
| req_user | output | 1 | User-translation variant |
| req_unpred | output | 1 | Unpredictable-case indicator |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 2 | Exception cause code |
| nop_done | output | 1 | Word completed as a no-op |

## Verification
Several verdicts can apply to the same word in the same cycle. An exception check can meet an uncached no-op, an unused operation number can meet an uncached attribute, and an index operation to a mapped address can meet an uncached attribute on an old revision. The bench provokes these by holding the attribute at an uncached value while it sweeps every combination of presence bits, memory-system flag, feature support and coprocessor enable. It also sweeps all operation numbers across every attribute, both revision ranges and both mapping states. Each outcome is judged against a priority model in the bench: the exception cause wins, then the unused-op no-op, then the uncached no-op, and the unpredictable flag rides on an issued request.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_RI   = 2'd1,
        CAUSE_CPU  = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        CLS_INDEX = 2'd0,
        CLS_IMPL  = 2'd1,
        CLS_HIT   = 2'd2
    } class_e;

    localparam logic [5:0] MAJOR_OPC = 6'b101001;
    localparam logic [3:0] MINOR_OPC = 4'b0111;
    localparam logic [1:0] SEL_NORM  = 2'b01;
    localparam logic [1:0] SEL_USER  = 2'b10;
    localparam int         IMM_W     = 9;
    localparam int         OPN_W     = 5;
    localparam int         REGN_W    = 5;
endpackage

// File: rtl/cmd_fields.sv
module cmd_fields
    import cmd_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic [31:0]       instr,
    output logic              match,
    output logic [OPN_W-1:0]  op,
    output logic [REGN_W-1:0] base,
    output logic              user,
    output logic [OFF_W-1:0]  offset
);
    localparam int EXT_W = OFF_W - IMM_W;

    logic [IMM_W-1:0] imm;
    logic [1:0]       sel;

    assign sel   = instr[9:8];
    assign imm   = {instr[15], instr[7:0]};
    assign op    = instr[25:21];
    assign base  = instr[20:16];
    assign user  = (sel == SEL_USER);
    assign match = (instr[31:26] == MAJOR_OPC) && (instr[14:11] == MINOR_OPC) &&
                   !instr[10] && ((sel == SEL_NORM) || (sel == SEL_USER));

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            assign offset = imm[OFF_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cmd_legal.sv
module cmd_legal
    import cmd_pkg::*;
#(
    parameter int          REV_W       = 3,
    parameter int          CCA_W       = 3,
    parameter int          N_CACHE     = 5,
    parameter int          NOOP_REV    = 2,
    parameter int          CCA_UC_A    = 2,
    parameter int          CCA_UC_B    = 7,
    parameter int          INDEX_LAST  = 11,
    parameter int          IMPL_LAST   = 15,
    parameter logic [31:0] UNUSED_MASK = 32'hC100_0000
) (
    input  logic [OPN_W-1:0]   op,
    input  logic               user,
    input  logic               no_memsys,
    input  logic [N_CACHE-1:0] present,
    input  logic               uxlate_ok,
    input  logic [REV_W-1:0]   arch_rev,
    input  logic               cp0_en,
    input  logic [CCA_W-1:0]   cca,
    input  logic               addr_mapped,
    output logic               exc,
    output cause_e             cause,
    output logic               nop,
    output logic               go,
    output class_e             cls,
    output logic [1:0]         level,
    output logic               unpred
);
    logic uncached, rev_new, unused, is_index;

    assign uncached = (cca == CCA_W'(CCA_UC_A)) || (cca == CCA_W'(CCA_UC_B));
    assign rev_new  = (arch_rev >= REV_W'(NOOP_REV));
    assign unused   = UNUSED_MASK[op];
    assign is_index = (op <= OPN_W'(INDEX_LAST));
    assign level    = op[1:0];

    always_comb begin
        exc   = 1'b0;
        cause = CAUSE_NONE;
        nop   = 1'b0;
        go    = 1'b0;
        if (no_memsys && (present == '0)) begin
            exc   = 1'b1;
            cause = CAUSE_RI;
        end else if (user && !uxlate_ok) begin
            exc   = 1'b1;
            cause = CAUSE_RI;
        end else if (!cp0_en) begin
            exc   = 1'b1;
            cause = CAUSE_CPU;
        end else if (unused || (uncached && rev_new)) begin
            nop = 1'b1;
        end else begin
            go = 1'b1;
        end
    end

    always_comb begin
        if (is_index)                        cls = CLS_INDEX;
        else if (op <= OPN_W'(IMPL_LAST))    cls = CLS_IMPL;
        else                                 cls = CLS_HIT;
    end

    assign unpred = (is_index && addr_mapped) || (uncached && !rev_new);
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import cmd_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int REV_W = 3,
    parameter int CCA_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic             no_memsys,
    input  logic             has_l1i,
    input  logic             has_l1d,
    input  logic             has_sec,
    input  logic             has_ter,
    input  logic             has_l2ctl,
    input  logic             uxlate_ok,
    input  logic [REV_W-1:0] arch_rev,
    input  logic             cp0_en,
    input  logic [CCA_W-1:0] cca,
    input  logic             addr_mapped,
    output logic             req_valid,
    output logic [4:0]       req_op,
    output logic [4:0]       req_base,
    output logic [1:0]       req_level,
    output logic [1:0]       req_class,
    output logic [OFF_W-1:0] req_offset,
    output logic             req_user,
    output logic             req_unpred,
    output logic             exc_valid,
    output logic [1:0]       exc_cause,
    output logic             nop_done
);
    localparam int N_CACHE = 5;

    typedef struct packed {
        logic             req;
        logic             exc;
        logic [1:0]       cause;
        logic             nop;
        logic [4:0]       op;
        logic [4:0]       base;
        logic [1:0]       level;
        logic [1:0]       cls;
        logic [OFF_W-1:0] off;
        logic             user;
        logic             unpred;
    } dec_t;

    dec_t st_d, st_q;

    logic               f_match, f_user;
    logic [OPN_W-1:0]   f_op;
    logic [REGN_W-1:0]  f_base;
    logic [OFF_W-1:0]   f_off;
    logic               l_exc, l_nop, l_go, l_unpred;
    cause_e             l_cause;
    class_e             l_cls;
    logic [1:0]         l_level;
    logic [N_CACHE-1:0] present;

    assign present = {has_l2ctl, has_ter, has_sec, has_l1d, has_l1i};

    cmd_fields #(.OFF_W(OFF_W)) u_fields (
        .instr  (instr),
        .match  (f_match),
        .op     (f_op),
        .base   (f_base),
        .user   (f_user),
        .offset (f_off)
    );

    cmd_legal #(.REV_W(REV_W), .CCA_W(CCA_W), .N_CACHE(N_CACHE)) u_legal (
        .op          (f_op),
        .user        (f_user),
        .no_memsys   (no_memsys),
        .present     (present),
        .uxlate_ok   (uxlate_ok),
        .arch_rev    (arch_rev),
        .cp0_en      (cp0_en),
        .cca         (cca),
        .addr_mapped (addr_mapped),
        .exc         (l_exc),
        .cause       (l_cause),
        .nop         (l_nop),
        .go          (l_go),
        .cls         (l_cls),
        .level       (l_level),
        .unpred      (l_unpred)
    );

    always_comb begin
        st_d = '0;
        if (in_valid && f_match) begin
            st_d.exc   = l_exc;
            st_d.cause = l_cause;
            st_d.nop   = l_nop;
            if (l_go) begin
                st_d.req    = 1'b1;
                st_d.op     = f_op;
                st_d.base   = f_base;
                st_d.level  = l_level;
                st_d.cls    = l_cls;
                st_d.off    = f_off;
                st_d.user   = f_user;
                st_d.unpred = l_unpred;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid  = st_q.req;
    assign req_op     = st_q.op;
    assign req_base   = st_q.base;
    assign req_level  = st_q.level;
    assign req_class  = st_q.cls;
    assign req_offset = st_q.off;
    assign req_user   = st_q.user;
    assign req_unpred = st_q.unpred;
    assign exc_valid  = st_q.exc;
    assign exc_cause  = st_q.cause;
    assign nop_done   = st_q.nop;
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk #(
    parameter int REV_W = 3,
    parameter int CCA_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cp0_en,
    input logic [REV_W-1:0] arch_rev,
    input logic [CCA_W-1:0] cca,
    input logic             req_valid,
    input logic [4:0]       req_op,
    input logic [1:0]       req_class,
    input logic             exc_valid,
    input logic [1:0]       exc_cause,
    input logic             nop_done
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, exc_valid, nop_done}));  // R3
    AST_NO_STROBE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(req_valid || exc_valid || nop_done));  // R3
    AST_CAUSE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == 2'd1 || exc_cause == 2'd2));  // R4
    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_cause == 2'd0));  // R4
    AST_CPU_NEEDS_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == 2'd2) |-> !$past(cp0_en));  // R6
    AST_UNCACHED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !(($past(cca) == CCA_W'(2) || $past(cca) == CCA_W'(7)) &&
                        $past(arch_rev) >= REV_W'(2)));  // R8
    AST_UNUSED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !(req_op == 5'd24 || req_op == 5'd30 || req_op == 5'd31));  // R9
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 2'd0) |-> (req_op <= 5'd11));  // R7
endmodule

bind cmd_decoder cmd_decoder_chk #(.REV_W(REV_W), .CCA_W(CCA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cp0_en    (cp0_en),
    .arch_rev  (arch_rev),
    .cca       (cca),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_class (req_class),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .nop_done  (nop_done)
);

// File: tb/cmd_decoder_tb.sv
module cmd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        no_memsys = 1'b0, has_l1i = 1'b1, has_l1d = 1'b1, has_sec = 1'b1;
    logic        has_ter = 1'b1, has_l2ctl = 1'b1, uxlate_ok = 1'b1, cp0_en = 1'b1;
    logic [2:0]  arch_rev = 3'd2;
    logic [2:0]  cca = 3'd3;
    logic        addr_mapped = 1'b0;
    logic        req_valid, req_user, req_unpred, exc_valid, nop_done;
    logic [4:0]  req_op, req_base;
    logic [1:0]  req_level, req_class, exc_cause;
    logic [31:0] req_offset;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmd_decoder u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, {61'd0, req_valid, exc_valid, nop_done}, 64'd0);
    endtask

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] rs,
                                       input logic [1:0] sel, input logic [8:0] imm);
        return {6'b101001, op, rs, imm[8], 4'b0111, 1'b0, sel, imm[7:0]};
    endfunction

    task automatic run_one(input logic [4:0] op, input logic [4:0] rs,
                           input logic [1:0] sel, input logic [8:0] imm);
        logic       e_exc, e_nop, e_req, uc, e_unp;
        logic [1:0] e_cause, e_cls;
        string      tag;
        instr    = mk(op, rs, sel, imm);
        in_valid = 1'b1;
        uc       = (cca == 3'd2) || (cca == 3'd7);
        e_exc = 0; e_nop = 0; e_req = 0; e_cause = 0; tag = "R8";
        if (no_memsys && !(has_l1i | has_l1d | has_sec | has_ter | has_l2ctl)) begin
            e_exc = 1; e_cause = 1; tag = "R4";
        end else if (sel == 2'b10 && !uxlate_ok) begin
            e_exc = 1; e_cause = 1; tag = "R5";
        end else if (!cp0_en) begin
            e_exc = 1; e_cause = 2; tag = "R6";
        end else if (op == 5'd24 || op >= 5'd30) begin
            e_nop = 1; tag = "R9";
        end else if (uc && arch_rev >= 3'd2) begin
            e_nop = 1; tag = "R8";
        end else begin
            e_req = 1; tag = "R3";
        end
        e_cls = (op <= 5'd11) ? 2'd0 : (op <= 5'd15) ? 2'd1 : 2'd2;
        e_unp = ((op <= 5'd11) && addr_mapped) || (uc && arch_rev < 3'd2);
        @(negedge clk);
        chk(tag, {59'd0, req_valid, exc_valid, exc_cause, nop_done},
                 {59'd0, e_req, e_exc, e_cause, e_nop});
        if (e_req) begin
            chk("R2", {req_op, req_base, req_offset, req_user},
                      {op, rs, {{23{imm[8]}}, imm}, sel == 2'b10});
            chk("R7", {req_class, req_level}, {e_cls, op[1:0]});
            chk("R10", {63'd0, req_unpred}, {63'd0, e_unp});
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk_idle("R3");
    endtask

    task automatic run_bad(input logic [31:0] w);
        instr    = w;
        in_valid = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R3");
        chk("R4", {62'd0, exc_cause}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R3");

        // full op sweep against attributes, revisions and mapping
        for (int op = 0; op < 32; op++)
            for (int s = 1; s <= 2; s++)
                for (int c = 0; c < 8; c++)
                    for (int r = 1; r <= 2; r++)
                        for (int m = 0; m < 2; m++) begin
                            cca         = 3'(c);
                            arch_rev    = 3'(r);
                            addr_mapped = m[0];
                            run_one(5'(op), 5'(op ^ c), 2'(s), 9'((op * 37 + c * 11 + m) % 512));
                        end

        // legality priority sweep with an uncached target on a new revision
        cca = 3'd2; arch_rev = 3'd2; addr_mapped = 1'b0;
        for (int b = 0; b < 256; b++)
            for (int s = 1; s <= 2; s++) begin
                {cp0_en, uxlate_ok, has_l2ctl, has_ter, has_sec, has_l1d, has_l1i, no_memsys} = 8'(b);
                run_one(5'd21, 5'(b), 2'(s), 9'(b));
                run_one(5'd24, 5'(b), 2'(s), 9'(b));
            end
        {cp0_en, uxlate_ok, has_l2ctl, has_ter, has_sec, has_l1d, has_l1i, no_memsys} = 8'hFE;

        // offset extremes R2
        cca = 3'd3;
        run_one(5'd17, 5'd31, 2'b01, 9'h000);
        run_one(5'd17, 5'd0,  2'b10, 9'h0FF);
        run_one(5'd17, 5'd9,  2'b01, 9'h100);
        run_one(5'd17, 5'd5,  2'b10, 9'h1FF);

        // malformed words R1
        run_bad(mk(5'd1, 5'd2, 2'b00, 9'h3));
        run_bad(mk(5'd1, 5'd2, 2'b11, 9'h3));
        run_bad(mk(5'd1, 5'd2, 2'b01, 9'h3) ^ 32'h0400_0000);
        run_bad(mk(5'd1, 5'd2, 2'b01, 9'h3) ^ 32'h0000_0800);
        run_bad(mk(5'd1, 5'd2, 2'b01, 9'h3) | 32'h0000_0400);
        run_bad(32'h0000_0000);
        @(negedge clk);
        chk_idle("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule